// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block carries out one multi-register memory transfer. A request pulse hands it a 32-bit transfer word and the current value of the base register. The block then works through the 16-bit register mask. For each selected register it issues exactly one word access to an external memory port, and it moves data between that port and an external register file. Loads go into the register file and stores come out of it. When the last access has been acknowledged, the block can return the final running address to the base register.

The transfer word selects four things: which way the mask is walked, whether the address steps before or after each access, whether data is loaded or stored, and whether the base is written back. Two encodings are refused. For those the block raises an undefined-transfer flag and touches neither memory nor registers. The register file is read and written through one index port. Memory is a single request/acknowledge channel that holds one access in flight.

Top module: `blkx_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `undef_flag`, `mem_req` and `rf_we` are all low.
- R2: Transfer-word fields are: pre-step bit 24, ascending bit 23, refused bit 22, writeback bit 21, load bit 20, base index bits 19:16 and register mask bits 15:0. A word with bit 22 set or mask bit 15 set asserts `undef_flag` together with `done`. It issues no memory access and writes no register.
- R3: With bit 23 set, selected registers are visited from the lowest index upward and the address rises by 4 per access. With bit 23 clear, they are visited from the highest index downward and the address falls by 4 per access.
- R4: With bit 24 set, the address moves by 4 before each access, so the first access is at base±4. With bit 24 clear, the address moves after each access, so the first access is at the base.
- R5: Registers whose mask bit is clear get no access. Every selected register gets exactly one.
- R6: With bit 20 set, each acknowledged access writes `mem_rdata` into the register named by `rf_idx`. With bit 20 clear, `mem_we` is high and `mem_wdata` carries that register's value.
- R7: With bit 21 set, the base register receives base + 4·N (ascending) or base − 4·N (descending) after the last access, where N is the count of selected registers. This writeback overrides a load into the base. With bit 21 clear, the base is written only if it is loaded.
- R8: An empty mask issues no access. Without writeback, `done` comes one cycle after the start is captured. With writeback, the base is rewritten with its unchanged value one cycle later.
- R9: `busy` is high from the cycle after start until and including the single-cycle `done` pulse. A `start` seen while busy is ignored.
- R10: `mem_req` stays high with a stable `mem_addr` and `rf_idx` until `mem_ack`. Exactly one access completes per acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| instr | input | 32 | Transfer word |
| base_val | input | 32 | Current value of the base register |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| undef_flag | output | 1 | Refused encoding, valid with done |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Access accepted/completed |
| mem_rdata | input | 32 | Load data, valid with mem_ack |
| rf_idx | output | 4 | Register file index for read and write |
| rf_rdata | input | 32 | Register file read data for rf_idx |
| rf_we | output | 1 | Register file write strobe |
| rf_wdata | output | 32 | Register file write data |

## Verification
The assertions assume three things about the inputs. `mem_ack` arrives only while `mem_req` is high. `rf_rdata` follows `rf_idx` in the same cycle. `base_val` equals the register that the base field names. The bench meets these by construction. Its memory model raises an acknowledge only in answer to a pending request, after a varying wait of zero to two cycles. It returns the bench's own register array combinationally, and it always presents the base from that same array. It also drives stray start pulses only while a transfer is running.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_XFER  = 2'd2,
    ST_WB    = 2'd3
  } blkx_state_e;

  // bit positions inside the transfer word
  localparam int unsigned POS_PRE     = 24;
  localparam int unsigned POS_UP      = 23;
  localparam int unsigned POS_SYS     = 22;
  localparam int unsigned POS_WB      = 21;
  localparam int unsigned POS_LOAD    = 20;
  localparam int unsigned POS_BASE_LO = 16;
endpackage

// File: rtl/blkx_decode.sv
module blkx_decode
  import blkx_pkg::*;
#(
  parameter int unsigned IW   = 32,
  parameter int unsigned NREG = 16,
  localparam int unsigned RIW = $clog2(NREG)
) (
  input  logic [IW-1:0]  instr,
  output logic           pre,
  output logic           up,
  output logic           wbk,
  output logic           ld,
  output logic [RIW-1:0] base_idx,
  output logic           is_undef
);
  logic [NREG-1:0] mask;
  logic            refused_bit;
  logic            unused_hi;

  assign mask        = instr[NREG-1:0];
  assign pre         = instr[POS_PRE];
  assign up          = instr[POS_UP];
  assign refused_bit = instr[POS_SYS];
  assign wbk         = instr[POS_WB];
  assign ld          = instr[POS_LOAD];
  assign base_idx    = instr[POS_BASE_LO +: RIW];
  assign unused_hi   = ^{instr[IW-1:POS_PRE+1], mask[NREG-2:0]};

  // the top register cannot be moved by this block, and the refused bit is rejected
  assign is_undef = refused_bit | mask[NREG-1];
endmodule

// File: rtl/blkx_pick.sv
module blkx_pick #(
  parameter int unsigned NREG = 16,
  localparam int unsigned RIW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] pend,
  input  logic            up,
  output logic [RIW-1:0]  idx,
  output logic            any,
  output logic            last
);
  function automatic logic [RIW-1:0] lowest_set(input logic [NREG-1:0] v);
    lowest_set = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (v[i]) lowest_set = RIW'(i);
  endfunction

  function automatic logic [RIW-1:0] highest_set(input logic [NREG-1:0] v);
    highest_set = '0;
    for (int i = 0; i < NREG; i++)
      if (v[i]) highest_set = RIW'(i);
  endfunction

  assign idx  = up ? lowest_set(pend) : highest_set(pend);
  assign any  = |pend;
  assign last = any && ((pend & (pend - NREG'(1))) == '0);

  // R5: the chosen register is always one still pending
  a_r5_pick_listed: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> pend[idx]);

  // R3: nothing pending lies on the near side of the chosen index
  a_r3_pick_order: assert property (@(posedge clk) disable iff (!rst_n)
    (any && up) |-> ((pend & ((NREG'(1) << idx) - NREG'(1))) == '0));
  a_r3_pick_order_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (any && !up) |-> ((pend >> idx) == NREG'(1)));
endmodule

// File: rtl/blkx_addr.sv
module blkx_addr #(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] base,
  input  logic          step_en,
  input  logic          up,
  input  logic          pre,
  output logic [AW-1:0] acc_addr,
  output logic [AW-1:0] run_addr
);
  logic [AW-1:0] run_q;

  function automatic logic [AW-1:0] stride(input logic [AW-1:0] a, input logic dir_up);
    stride = dir_up ? a + AW'(STEP) : a - AW'(STEP);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (load_en) run_q <= base;
    else if (step_en) run_q <= stride(run_q, up);
  end

  assign acc_addr = pre ? stride(run_q, up) : run_q;
  assign run_addr = run_q;

  // R4: the running address starts from the base
  a_r4_start_at_base: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> run_q == $past(base));

  // R3: each completed access moves the running address by one word
  a_r3_stride: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en) |=>
      (($past(up) ? run_q - $past(run_q) : $past(run_q) - run_q) == AW'(STEP)));
endmodule

// File: rtl/blkx_seq.sv
module blkx_seq
  import blkx_pkg::*;
#(
  parameter int unsigned IW   = 32,
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 16,
  parameter int unsigned STEP = 4,
  localparam int unsigned RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [IW-1:0]  instr,
  input  logic [AW-1:0]  base_val,
  output logic           busy,
  output logic           done,
  output logic           undef_flag,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata,
  output logic [RIW-1:0] rf_idx,
  input  logic [DW-1:0]  rf_rdata,
  output logic           rf_we,
  output logic [DW-1:0]  rf_wdata
);
  blkx_state_e     state_q, state_d;
  logic [IW-1:0]   instr_q;
  logic [NREG-1:0] pend_q;

  logic            pre, up, wbk, ld, is_undef;
  logic [RIW-1:0]  base_idx, pick_idx;
  logic            any, last;
  logic [AW-1:0]   acc_addr, run_addr;

  // named internal events
  logic ev_capture, ev_step, ev_last_step, ev_refuse, ev_empty;

  blkx_decode #(.IW(IW), .NREG(NREG)) u_dec (
    .instr(instr_q), .pre(pre), .up(up), .wbk(wbk), .ld(ld),
    .base_idx(base_idx), .is_undef(is_undef)
  );

  blkx_pick #(.NREG(NREG)) u_pick (
    .clk(clk), .rst_n(rst_n), .pend(pend_q), .up(up),
    .idx(pick_idx), .any(any), .last(last)
  );

  blkx_addr #(.AW(AW), .STEP(STEP)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_en(ev_capture), .base(base_val),
    .step_en(ev_step), .up(up), .pre(pre),
    .acc_addr(acc_addr), .run_addr(run_addr)
  );

  assign ev_capture   = (state_q == ST_IDLE) && start;
  assign ev_step      = (state_q == ST_XFER) && mem_ack;
  assign ev_last_step = ev_step && last;
  assign ev_refuse    = (state_q == ST_CHECK) && is_undef;
  assign ev_empty     = (state_q == ST_CHECK) && !is_undef && !any;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_CHECK;
      ST_CHECK: begin
        if (is_undef)  state_d = ST_IDLE;
        else if (!any) state_d = wbk ? ST_WB : ST_IDLE;
        else           state_d = ST_XFER;
      end
      ST_XFER:  if (ev_last_step) state_d = wbk ? ST_WB : ST_IDLE;
      ST_WB:    state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      instr_q <= '0;
      pend_q  <= '0;
    end else begin
      state_q <= state_d;
      if (ev_capture) begin
        instr_q <= instr;
        pend_q  <= instr[NREG-1:0];
      end else if (ev_step) begin
        pend_q <= pend_q & ~(NREG'(1) << pick_idx);
      end
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign mem_req    = (state_q == ST_XFER);
  assign mem_we     = !ld;
  assign mem_addr   = acc_addr;
  assign mem_wdata  = rf_rdata;
  assign rf_idx     = (state_q == ST_WB) ? base_idx : pick_idx;
  assign rf_we      = (ev_step && ld) || (state_q == ST_WB);
  assign rf_wdata   = (state_q == ST_WB) ? DW'(run_addr) : mem_rdata;
  assign undef_flag = ev_refuse;
  assign done       = ev_refuse || (ev_empty && !wbk) ||
                      (ev_last_step && !wbk) || (state_q == ST_WB);

  // R10: a waiting request keeps its address and register
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(rf_idx)));

  // R10: each acknowledge retires exactly one pending register
  a_r10_one_per_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));

  // R9: completion is a single pulse inside the busy window
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R2: a refused word ends quietly
  a_r2_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    undef_flag |-> (done && !mem_req && !rf_we));
  a_r2_undef_no_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    undef_flag |=> !busy);

  // R6: a store never writes the register file
  a_r6_store_no_rf: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !rf_we);

  // R8: an empty mask never reaches the access state
  a_r8_empty_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    ev_empty |=> !mem_req);
endmodule

// File: tb/sim_blkx_seq.sv
`timescale 1ns/1ps
module sim_blkx_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] instr, base_val;
  logic        busy, done, undef_flag;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic [3:0]  rf_idx;
  logic [31:0] rf_rdata;
  logic        rf_we;
  logic [31:0] rf_wdata;

  always #4 clk = ~clk;

  blkx_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .base_val(base_val),
    .busy(busy), .done(done), .undef_flag(undef_flag),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rf_idx(rf_idx), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata)
  );

  logic [31:0] rf_m [16];
  assign rf_rdata = rf_m[rf_idx];
  always @(posedge clk) if (rf_we) rf_m[rf_idx] <= rf_wdata;

  typedef struct {
    bit          we;
    logic [31:0] addr;
    int          idx;
    logic [31:0] data;
  } item_t;
  item_t q[$];

  int total = 0;
  int bad = 0;
  int acc_n = 0;
  int wcnt = 0;
  bit hold_v = 0;
  logic [31:0] hold_addr;

  function automatic logic [31:0] memv(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  function automatic logic [31:0] mk(input bit p, input bit u, input bit s, input bit w,
                                     input bit l, input int rn, input logic [15:0] lst);
    return {4'hE, 3'b100, p, u, s, w, l, 4'(rn), lst};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    #1;
  endtask

  // memory responder and scoreboard monitor
  always @(negedge clk) begin : mon
    item_t e;
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wcnt > 0) begin
        wcnt--;
        if (!hold_v) begin hold_v = 1; hold_addr = mem_addr; end
      end else begin
        acc_n++;
        if (hold_v) chk(mem_addr == hold_addr, "R10", "address held while waiting", mem_addr, hold_addr);
        hold_v = 0;
        if (q.size() == 0) begin
          chk(0, "R5", "unexpected access", mem_addr, 32'h0);
        end else begin
          e = q.pop_front();
          chk(rf_idx == 4'(e.idx), "R3", "register order", 32'(rf_idx), 32'(e.idx));
          chk(mem_addr == e.addr, "R4", "access address", mem_addr, e.addr);
          chk(mem_we == e.we, "R6", "direction", 32'(mem_we), 32'(e.we));
          if (e.we) chk(mem_wdata == e.data, "R6", "store data", mem_wdata, e.data);
        end
        mem_rdata = memv(mem_addr);
        mem_ack = 1'b1;
        wcnt = acc_n % 3;
      end
    end
  end

  // driver: builds the expected access list and final register image
  task automatic run_op(input logic [31:0] ins, input int exp_lat, input bit spam);
    logic [31:0] e [16];
    logic [31:0] a;
    int rn, n, i;
    bit undefx, busy_ok;
    item_t it;
    rn = int'(ins[19:16]);
    undefx = ins[22] | ins[15];
    for (int k = 0; k < 16; k++) e[k] = rf_m[k];
    if (!undefx) begin
      a = rf_m[rn];
      for (int k = 0; k < 16; k++) begin
        i = ins[23] ? k : 15 - k;
        if (ins[i]) begin
          if (ins[24]) a = ins[23] ? a + 4 : a - 4;
          it.we = !ins[20]; it.addr = a; it.idx = i; it.data = rf_m[i];
          q.push_back(it);
          if (ins[20]) e[i] = memv(a);
          if (!ins[24]) a = ins[23] ? a + 4 : a - 4;
        end
      end
      if (ins[21]) e[rn] = a;
    end
    instr = ins; base_val = rf_m[rn]; start = 1'b1;
    tick;
    start = 1'b0;
    n = 1; busy_ok = 1;
    while (!done && n < 3000) begin
      if (!busy) busy_ok = 0;
      if (spam && n == 2) begin start = 1'b1; instr = 32'h01C0_7FFF; end
      else start = 1'b0;
      tick;
      n++;
    end
    start = 1'b0;
    chk(done, "R9", "done observed", 32'(done), 32'h1);
    chk(busy_ok && busy, "R9", "busy held through done", 32'(busy_ok), 32'h1);
    chk(undef_flag == undefx, "R2", "undefined flag", 32'(undef_flag), 32'(undefx));
    if (exp_lat >= 0) chk(n == exp_lat, "R8", "completion latency", 32'(n), 32'(exp_lat));
    tick;
    chk(!busy && !done, "R9", "idle after single done pulse", {30'h0, busy, done}, 32'h0);
    chk(q.size() == 0, "R5", "all selected registers accessed", 32'(q.size()), 32'h0);
    chk(rf_m[rn] == e[rn], undefx ? "R2" : "R7", "base register", rf_m[rn], e[rn]);
    for (int k = 0; k < 16; k++)
      if (k != rn && rf_m[k] !== e[k]) begin
        chk(0, undefx ? "R2" : "R6", $sformatf("register %0d", k), rf_m[k], e[k]);
      end
    total++;
    q.delete();
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; instr = '0; base_val = '0;
    mem_ack = 1'b0; mem_rdata = '0;
    for (int k = 0; k < 16; k++) rf_m[k] = 32'h0001_0000 + 32'(k) * 32'h100;
    repeat (3) tick;
    // R1 during reset
    chk({busy, done, undef_flag, mem_req, rf_we} == 5'b0, "R1", "outputs in reset",
        {27'h0, busy, done, undef_flag, mem_req, rf_we}, 32'h0);
    rst_n = 1'b1;
    tick;
    chk({busy, done, undef_flag, mem_req, rf_we} == 5'b0, "R1", "outputs after reset",
        {27'h0, busy, done, undef_flag, mem_req, rf_we}, 32'h0);

    // R3 R4 R6 R7: ascending, step after, load, writeback
    run_op(mk(0, 1, 0, 1, 1, 13, 16'h0025), -1, 0);
    // R3 R4 R6 R7: descending, step before, store, writeback
    run_op(mk(1, 0, 0, 1, 0, 13, 16'h401A), -1, 0);
    // R5 R7: ascending pre-step load including the base, no writeback
    run_op(mk(1, 1, 0, 0, 1, 2, 16'h00FF), -1, 0);
    // R5: descending post-step store of one register
    run_op(mk(0, 0, 0, 0, 0, 9, 16'h0080), -1, 0);
    // R2: mask bit 15 refused
    run_op(mk(0, 1, 0, 1, 1, 3, 16'h8001), 1, 0);
    // R2: refused bit 22
    run_op(mk(1, 1, 1, 1, 0, 3, 16'h0006), 1, 0);
    // R8: empty mask without writeback
    run_op(mk(0, 1, 0, 0, 1, 5, 16'h0000), 1, 0);
    // R8: empty mask with writeback keeps base
    run_op(mk(1, 0, 0, 1, 0, 5, 16'h0000), 2, 0);
    // R9: stray start while busy ignored
    run_op(mk(0, 1, 0, 1, 0, 11, 16'h0C31), -1, 1);
    // R7: descending pre-step load with base in mask, writeback wins
    run_op(mk(1, 0, 0, 1, 1, 4, 16'h0052), -1, 0);
    // R6: store everything below the top, ascending
    run_op(mk(0, 1, 0, 0, 0, 0, 16'h7FFF), -1, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule